// File: doc/BRIEF.md
# FIFO Flag Offset Programmer

This block keeps the two threshold values a synchronous FIFO compares its fill level against: the almost-empty offset and the almost-full offset. Each offset is `OFS_W` bits wide and is reached through two bus words. The low word carries offset bits `[WORD_W-1:0]`. The high word carries the bits above that, right-aligned and zero-extended. Together the two offsets make four words. Each port steps through them in a fixed rotation: empty-low (index 0), empty-high (1), full-low (2), full-high (3), then back to index 0.

Master reset fixes two things until the next reset. The first is the default offset value, chosen by the program-select pin. The second is the loading method: serial, one bit per write-clock edge, or parallel, one word per write-clock edge. The words can be read back in the same rotation on the read clock with either method. While the program-select pin is high, the write and read enables pass through as memory-access strobes, and the offset logic does nothing.

Top module: `fifo_ofs_prog`

## Requirements
- R1: While `rst_ni` is low, both offsets load 0x03FF if `prog_ni` is high and 0x007F if it is low. All offset bits from `WORD_W` upward are zero. `rdata_o` resets to 0.
- R2: During master reset, `ser_en_ni` low selects serial loading and high selects parallel loading. The selection holds until the next reset, whatever `ser_en_ni` does afterwards. Both word pointers reset to index 0.
- R3: In parallel mode, a write-clock edge with `prog_ni`=0, `wr_en_ni`=0 and `rd_en_ni`=1 stores `wdata_i` into the word at the write pointer, and the write pointer advances. A high word takes only its low `OFS_W-WORD_W` data bits. Serial and parallel loads never happen on the same edge.
- R4: Each word pointer wraps from index 3 to index 0.
- R5: A read-clock edge with `prog_ni`=0, `rd_en_ni`=0 and `wr_en_ni`=1 registers the word at the read pointer onto `rdata_o` and advances the read pointer. High words read back zero-extended. Otherwise `rdata_o` holds its value.
- R6: Parallel read-back works the same way in serial mode and in parallel mode.
- R7: In serial mode, a write-clock edge with `prog_ni`=0, `ser_en_ni`=0, `wr_en_ni`=1 and `rd_en_ni`=1 stores `ser_d_i` into bit k of the 2·`OFS_W`-bit vector {full, empty}, where k is the bit counter. The first bit after reset goes to empty bit 0. The counter wraps to 0 after bit 2·`OFS_W`-1.
- R8: Parallel writes in serial mode change no offset and do not advance the write pointer. Serial shifts in parallel mode change no offset.
- R9: With `prog_ni` high, `mem_wr_o`=!`wr_en_ni` and `mem_rd_o`=!`rd_en_ni`, and no offset, pointer, counter or read-back changes. With `prog_ni` low, both strobes are 0. With `prog_ni` low and both enables low, or with no enable active, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock; drives loading |
| rclk_i | input | 1 | Read clock; drives read-back |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| prog_ni | input | 1 | Low: offset access; high: memory access. Picks the default value at reset |
| ser_en_ni | input | 1 | Active-low serial shift enable; selects the loading method at reset |
| wr_en_ni | input | 1 | Active-low write enable |
| rd_en_ni | input | 1 | Active-low read enable |
| ser_d_i | input | 1 | Serial offset data |
| wdata_i | input | WORD_W | Parallel offset word |
| emp_ofs_o | output | OFS_W | Almost-empty offset |
| ful_ofs_o | output | OFS_W | Almost-full offset |
| rdata_o | output | WORD_W | Read-back word |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |

## Verification
The bench writes all four words plus one more. A pointer that fails to wrap puts the fifth word in the wrong place or corrupts the full offset. A high-word write of 0xFFFF checks that only the real upper bits land. The bench shifts a full 34-bit pattern, then three more bits, to catch a counter that fails to wrap or that fills the wrong end first. It tries each loading method in the mode that forbids it, and tries edges with both enables low or with program-select high. A design that acted on any of these would change an offset or shift the read-back rotation, and the next read exposes the shifted rotation.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
  typedef enum logic [1:0] {
    SEL_EMP_LO = 2'd0,
    SEL_EMP_HI = 2'd1,
    SEL_FUL_LO = 2'd2,
    SEL_FUL_HI = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(ofs_sel_e s);
    logic [1:0] v;
    v = s;
    v = v + 2'd1;
    return ofs_sel_e'(v);
  endfunction
endpackage

// File: rtl/ofs_word_ptr.sv
module ofs_word_ptr
  import fifo_ofs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  output ofs_sel_e sel_o
);
  ofs_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= SEL_EMP_LO;
    else if (adv_i) sel_q <= sel_next(sel_q);
  end

  assign sel_o = sel_q;

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && sel_q == SEL_FUL_HI |=> sel_q == SEL_EMP_LO); // R4
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sel_q)); // R9
endmodule

// File: rtl/ofs_bit_ctr.sv
module ofs_bit_ctr #(
  parameter int CNT_MAX = 34,
  localparam int IDX_W = $clog2(CNT_MAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CNT_MAX - 1);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && idx_q == LAST |=> idx_q == '0); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q)); // R9
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import fifo_ofs_pkg::*;
#(
  parameter int OFS_W      = 17,
  parameter int WORD_W     = 16,
  parameter int DEF_HI_VAL = 'h3FF,
  parameter int DEF_LO_VAL = 'h7F,
  localparam int TOT_W = 2 * OFS_W,
  localparam int IDX_W = $clog2(TOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dflt_hi_i,
  input  logic              wr_en_i,
  input  ofs_sel_e          wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              sh_en_i,
  input  logic [IDX_W-1:0]  sh_idx_i,
  input  logic              sh_bit_i,
  output logic [OFS_W-1:0]  emp_o,
  output logic [OFS_W-1:0]  ful_o
);
  logic [TOT_W-1:0] bits_w;

  for (genvar k = 0; k < TOT_W; k++) begin : g_bit
    localparam int         POS    = k % OFS_W;
    localparam bit         IS_FUL = (k >= OFS_W);
    localparam bit         IS_LO  = (POS < WORD_W);
    localparam logic [1:0] SEL    = {IS_FUL, !IS_LO};
    localparam int         DPOS   = IS_LO ? POS : POS - WORD_W;
    localparam bit         RV_HI  = IS_LO && (((DEF_HI_VAL >> POS) & 1) != 0);
    localparam bit         RV_LO  = IS_LO && (((DEF_LO_VAL >> POS) & 1) != 0);
    logic bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bit_q <= dflt_hi_i ? RV_HI : RV_LO;
      else if (sh_en_i && sh_idx_i == IDX_W'(k))
        bit_q <= sh_bit_i;
      else if (wr_en_i && wr_sel_i == SEL)
        bit_q <= wr_data_i[DPOS];
    end

    assign bits_w[k] = bit_q;
  end

  assign emp_o = bits_w[OFS_W-1:0];
  assign ful_o = bits_w[TOT_W-1:OFS_W];

  AST_ONE_LOADER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sh_en_i && wr_en_i)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sh_en_i && !wr_en_i |=> $stable(bits_w)); // R9
endmodule

// File: rtl/fifo_ofs_prog.sv
module fifo_ofs_prog
  import fifo_ofs_pkg::*;
#(
  parameter int OFS_W      = 17,
  parameter int WORD_W     = 16,
  parameter int DEF_HI_VAL = 'h3FF,
  parameter int DEF_LO_VAL = 'h7F,
  localparam int HI_W  = OFS_W - WORD_W,
  localparam int TOT_W = 2 * OFS_W,
  localparam int IDX_W = $clog2(TOT_W)
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prog_ni,
  input  logic              ser_en_ni,
  input  logic              wr_en_ni,
  input  logic              rd_en_ni,
  input  logic              ser_d_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [OFS_W-1:0]  emp_ofs_o,
  output logic [OFS_W-1:0]  ful_ofs_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o
);
  logic             ser_mode_q;
  logic             par_wr_req, par_wr, sh_req, sh_go, rd_go;
  ofs_sel_e         wr_sel, rd_sel;
  logic [IDX_W-1:0] sh_idx;
  logic [OFS_W-1:0] emp_w, ful_w;
  logic [WORD_W-1:0] rd_word, rdata_q;

  // loading method latched while reset is asserted
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) ser_mode_q <= !ser_en_ni;
  end

  assign par_wr_req = !prog_ni && !wr_en_ni && rd_en_ni;
  assign sh_req     = !prog_ni && !ser_en_ni && wr_en_ni && rd_en_ni;
  assign par_wr     = par_wr_req && !ser_mode_q;
  assign sh_go      = sh_req && ser_mode_q;
  assign rd_go      = !prog_ni && !rd_en_ni && wr_en_ni;

  assign mem_wr_o = prog_ni && !wr_en_ni;
  assign mem_rd_o = prog_ni && !rd_en_ni;

  ofs_word_ptr i_wr_ptr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .adv_i (par_wr),
    .sel_o (wr_sel)
  );

  ofs_bit_ctr #(.CNT_MAX(TOT_W)) i_bit_ctr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .step_i(sh_go),
    .idx_o (sh_idx)
  );

  ofs_store #(
    .OFS_W     (OFS_W),
    .WORD_W    (WORD_W),
    .DEF_HI_VAL(DEF_HI_VAL),
    .DEF_LO_VAL(DEF_LO_VAL)
  ) i_store (
    .clk_i    (wclk_i),
    .rst_ni   (rst_ni),
    .dflt_hi_i(prog_ni),
    .wr_en_i  (par_wr),
    .wr_sel_i (wr_sel),
    .wr_data_i(wdata_i),
    .sh_en_i  (sh_go),
    .sh_idx_i (sh_idx),
    .sh_bit_i (ser_d_i),
    .emp_o    (emp_w),
    .ful_o    (ful_w)
  );

  ofs_word_ptr i_rd_ptr (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .adv_i (rd_go),
    .sel_o (rd_sel)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_EMP_LO: rd_word = emp_w[WORD_W-1:0];
      SEL_EMP_HI: rd_word = WORD_W'(emp_w[OFS_W-1:WORD_W]);
      SEL_FUL_LO: rd_word = ful_w[WORD_W-1:0];
      default:    rd_word = WORD_W'(ful_w[OFS_W-1:WORD_W]);
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_word;
  end

  assign emp_ofs_o = emp_w;
  assign ful_ofs_o = ful_w;
  assign rdata_o   = rdata_q;

  AST_MODE_LOCK: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(ser_mode_q)); // R2
  AST_PAR_IN_SER: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ser_mode_q && par_wr_req |=> $stable({ful_w, emp_w}) && $stable(wr_sel)); // R8
  AST_SER_IN_PAR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !ser_mode_q && sh_req |=> $stable({ful_w, emp_w}) && $stable(sh_idx)); // R8
  AST_RD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(rdata_q)); // R5
  AST_HI_ZEXT: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_go && rd_sel == SEL_FUL_HI |=> rdata_q[WORD_W-1:HI_W] == '0); // R5
endmodule

// File: tb/test_fifo_ofs_prog.sv
module test_fifo_ofs_prog;
  localparam int OW = 17;
  localparam int WW = 16;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b1, prog_n = 1'b1, sen_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1, sd = 1'b0;
  logic [WW-1:0] wd = '0;
  logic [OW-1:0] emp, ful;
  logic [WW-1:0] rdata;
  logic mem_wr, mem_rd;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [WW-1:0] exp_q[$];
  logic [WW-1:0] exp_w;
  logic [2*OW-1:0] pat;

  fifo_ofs_prog i_fifo_ofs_prog (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prog_ni(prog_n),
    .ser_en_ni(sen_n), .wr_en_ni(wen_n), .rd_en_ni(ren_n), .ser_d_i(sd),
    .wdata_i(wd), .emp_ofs_o(emp), .ful_ofs_o(ful), .rdata_o(rdata),
    .mem_wr_o(mem_wr), .mem_rd_o(mem_rd)
  );

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change 3 ns after a read edge, well clear of both clock edges
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge rclk);
      #3;
    end
  endtask

  task automatic idle();
    prog_n = 1'b1; sen_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic do_reset(bit ld, bit ser);
    prog_n = ld; sen_n = !ser; wen_n = 1'b1; ren_n = 1'b1;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    idle();
    tick();
  endtask

  task automatic pwrite(logic [WW-1:0] d);
    prog_n = 1'b0; wen_n = 1'b0; ren_n = 1'b1; wd = d;
    tick();
    idle();
  endtask

  task automatic pread(logic [WW-1:0] e);
    exp_q.push_back(e);
    prog_n = 1'b0; ren_n = 1'b0; wen_n = 1'b1;
    tick();
    idle();
  endtask

  task automatic shift(logic b);
    prog_n = 1'b0; sen_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; sd = b;
    tick();
    idle();
  endtask

  // monitor: scores each read-back against the queue
  initial begin
    forever begin
      @(posedge rclk);
      if (rst_n && !prog_n && !ren_n && wen_n) begin
        #2;
        if (exp_q.size() == 0) begin
          chk("R5 unexpected read", 32'(rdata), 32'hFFFF_FFFF);
        end else begin
          exp_w = exp_q.pop_front();
          chk("R5 readback", 32'(rdata), 32'(exp_w));
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: defaults with program-select high, parallel mode
    do_reset(1'b1, 1'b0);
    chk("R1 empty default hi", 32'(emp), 32'h03FF);
    chk("R1 full default hi", 32'(ful), 32'h03FF);
    chk("R1 rdata reset", 32'(rdata), 32'h0);
    // R2 R4 R5: rotation from index 0 and wrap
    pread(16'h03FF); pread(16'h0000); pread(16'h03FF); pread(16'h0000); pread(16'h03FF);

    // R1: defaults with program-select low
    do_reset(1'b0, 1'b0);
    chk("R1 empty default lo", 32'(emp), 32'h007F);
    chk("R1 full default lo", 32'(ful), 32'h007F);

    // R9: memory strobes and no offset action when program-select high
    prog_n = 1'b1; wen_n = 1'b0; ren_n = 1'b1; wd = 16'h5555; #1;
    chk("R9 mem_wr", 32'(mem_wr), 32'h1);
    chk("R9 mem_rd idle", 32'(mem_rd), 32'h0);
    tick();
    prog_n = 1'b1; wen_n = 1'b1; ren_n = 1'b0; #1;
    chk("R9 mem_rd", 32'(mem_rd), 32'h1);
    tick();
    prog_n = 1'b0; wen_n = 1'b0; ren_n = 1'b0; #1;
    chk("R9 strobes off when programming", 32'({mem_wr, mem_rd}), 32'h0);
    tick();
    idle();
    chk("R9 empty untouched", 32'(emp), 32'h007F);
    chk("R9 full untouched", 32'(ful), 32'h007F);
    chk("R9 rdata untouched", 32'(rdata), 32'h0);
    pread(16'h007F); // R9: read pointer still at index 0

    // R3 R4: parallel load, fifth write wraps to empty-low
    pwrite(16'h1234); pwrite(16'hFFFF); pwrite(16'hABCD); pwrite(16'h0000);
    chk("R3 empty after writes", 32'(emp), 32'h11234);
    chk("R3 full after writes", 32'(ful), 32'h0ABCD);
    pwrite(16'h4321);
    chk("R4 write pointer wrap", 32'(emp), 32'h14321);
    chk("R4 full untouched by wrap", 32'(ful), 32'h0ABCD);
    // read pointer sits at index 1
    pread(16'h0001); pread(16'hABCD); pread(16'h0000); pread(16'h4321);

    // R8: serial shifts ignored in parallel mode
    for (int i = 0; i < 5; i++) shift(1'b1);
    chk("R8 empty unchanged by shift", 32'(emp), 32'h14321);
    chk("R8 full unchanged by shift", 32'(ful), 32'h0ABCD);

    // R2 R7: serial mode, full 2*OW-bit load
    do_reset(1'b1, 1'b1);
    chk("R2 serial reset empty", 32'(emp), 32'h03FF);
    pat = {17'h1C3A5, 17'h0F0F1};
    for (int k = 0; k < 2 * OW; k++) shift(pat[k]);
    chk("R7 empty serial", 32'(emp), 32'h0F0F1);
    chk("R7 full serial", 32'(ful), 32'h1C3A5);

    // R8: parallel write ignored in serial mode
    pwrite(16'hFFFF);
    chk("R8 empty unchanged by write", 32'(emp), 32'h0F0F1);
    chk("R8 full unchanged by write", 32'(ful), 32'h1C3A5);

    // R6: read-back in serial mode
    pread(16'hF0F1); pread(16'h0000); pread(16'hC3A5); pread(16'h0001);

    // R7: counter wrapped, next bits land in empty[2:0]
    shift(1'b0); shift(1'b0); shift(1'b0);
    chk("R7 counter wrap", 32'(emp), 32'h0F0F0);

    // R9: shift attempt with program-select high does nothing
    prog_n = 1'b1; sen_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; sd = 1'b1;
    tick(2);
    idle();
    chk("R9 no shift when program-select high", 32'(emp), 32'h0F0F0);
    shift(1'b1);
    chk("R9 counter not advanced", 32'(emp), 32'h0F0F8);
    chk("R7 full kept", 32'(ful), 32'h1C3A5);

    tick(2);
    chk("R5 all reads scored", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule